// File: doc/BRIEF.md
# Shared Segment / General-Purpose Output Pin Selector

This block sits between the waveform sequencer of a multiplexed LCD driver and the first eight output pins of the segment bank. Each of those pins can either carry the segment drive waveform or act as a static general-purpose output. Control software writes a small count. Pins numbered 1 up to that count become general-purpose outputs, and the rest keep their segment role. The selection is held in a register. It changes only when a new control word is loaded, so a transfer that is still in progress can never disturb the pins.

A general-purpose pin drives either full level or ground. The value comes from the first of the three display bits that the pin would use as a segment. A segment pin passes through the level code that the sequencer produces for it. In power-save mode, segment pins drop to ground while general-purpose pins keep following their data. When the inhibit input is low, every pin is forced back to its segment role and held at ground. The stored selection is kept, and it reappears as soon as inhibit goes high again. All results are registered, and every output changes one clock edge after the input that caused it.

Top module: `segport_mux`

## Requirements
- R1: After a load with count k (0 to 8), pins 1 through k act as general-purpose outputs and pins k+1 through 8 as segments; `port_mask` bit n-1 is 1 exactly when pin n is a general-purpose output, so the set bits always form a run starting at bit 0.
- R2: Count 0 makes all eight pins segments (`port_mask` = 8'h00), and count 8 makes all eight general-purpose outputs (`port_mask` = 8'hFF).
- R3: A general-purpose pin n drives level code 2'b11 (full) when `disp_data` bit 3(n-1) is 1, and 2'b00 (ground) when it is 0. The pin's other two display bits have no effect on it.
- R4: A segment pin n drives the code on `seg_lvl[2n-1:2n-2]` unchanged when inhibit is high and power-save is low. Level codes are 2'b00 ground, 2'b01 one third, 2'b10 two thirds, 2'b11 full.
- R5: Counts 9 to 15 give the same selection as 8.
- R6: The selection changes only on a cycle with `ctl_load` high; `ctl_count` is ignored on all other cycles.
- R7: With `psave` high, segment pins drive 2'b00 while general-purpose pins keep following their display bit.
- R8: With `inhibit_n` low, every pin drives 2'b00 and `port_mask` reads 8'h00. A load made during inhibit is still stored, and it shows once `inhibit_n` returns high.
- R9: Reset clears the outputs to 2'b00 and `port_mask` to zero at once, and leaves a stored count of 0, so all pins are segments.
- R10: `pin_lvl` and `port_mask` are registered and reflect the inputs sampled at the previous rising clock edge; nothing passes combinationally from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_load | input | 1 | Loads `ctl_count` into the selection register |
| ctl_count | input | 4 | Number of leading pins to use as general-purpose outputs |
| disp_data | input | 24 | Display bits for pins 1 to 8; bit 0 is the first bit of pin 1 |
| seg_lvl | input | 16 | Segment level code per pin from the sequencer, 2 bits per pin |
| inhibit_n | input | 1 | Low forces all pins to segment role at ground |
| psave | input | 1 | Power-save: segment pins go to ground |
| pin_lvl | output | 16 | Level code driven per pin, 2 bits per pin, pin 1 in bits 1:0 |
| port_mask | output | 8 | Bit n-1 set when pin n currently acts as a general-purpose output |

## Verification
Every result of this block, including a new pin selection from `ctl_load`, is due exactly one rising edge after the inputs are sampled. The bench therefore drives each stimulus at a falling edge, waits for one rising edge, and compares both outputs 1 ns later. A separate check samples the outputs between the drive and the next rising edge and confirms they still hold the old value. Reset is the one exception: it clears the outputs without waiting for the clock, so the bench checks them 1 ns after reset is asserted, with no clock edge in between.

// File: rtl/segport_pkg.sv
package segport_pkg;

  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_GND        = 2'b00,
    LVL_THIRD      = 2'b01,
    LVL_TWO_THIRDS = 2'b10,
    LVL_FULL       = 2'b11
  } lvl_e;

  // static output level of a pin used as a general-purpose output
  function automatic logic [LVL_W-1:0] port_level(input logic bitv);
    return bitv ? LVL_FULL : LVL_GND;
  endfunction

endpackage

// File: rtl/segport_rst_sync.sv
module segport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/segport_sel.sv
module segport_sel #(
  parameter int NPINS = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  output logic [NPINS-1:0] mask_next,
  output logic [NPINS-1:0] mask_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NPINS);

  logic [CNT_W-1:0] sat_cnt;
  logic [NPINS-1:0] therm;

  // saturate the count, then expand to a run of ones from pin 1
  always_comb begin
    sat_cnt = count;
    if (count > CNT_MAX) begin
      sat_cnt = CNT_MAX;
    end
    for (int i = 0; i < NPINS; i++) begin
      therm[i] = (CNT_W'(i) < sat_cnt);
    end
    mask_next = load ? therm : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= therm;
    end
  end

endmodule

// File: rtl/segport_cell.sv
module segport_cell
  import segport_pkg::*;
#(
  parameter int BITS_PER_PIN = 3
) (
  input  logic                    port_en,
  input  logic                    inhibit_n,
  input  logic                    psave,
  input  logic [BITS_PER_PIN-1:0] grp,
  input  logic [LVL_W-1:0]        seg_in,
  output logic [LVL_W-1:0]        lvl_out
);

  logic grp_unused;
  assign grp_unused = ^grp[BITS_PER_PIN-1:1];

  always_comb begin
    if (!inhibit_n) begin
      lvl_out = LVL_GND;
    end else if (port_en) begin
      lvl_out = port_level(grp[0]);
    end else if (psave) begin
      lvl_out = LVL_GND;
    end else begin
      lvl_out = seg_in;
    end
  end

endmodule

// File: rtl/segport_mux.sv
module segport_mux
  import segport_pkg::*;
#(
  parameter int NPINS        = 8,
  parameter int BITS_PER_PIN = 3,
  parameter int CNT_W        = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctl_load,
  input  logic [CNT_W-1:0]              ctl_count,
  input  logic [NPINS*BITS_PER_PIN-1:0] disp_data,
  input  logic [NPINS*LVL_W-1:0]        seg_lvl,
  input  logic                          inhibit_n,
  input  logic                          psave,
  output logic [NPINS*LVL_W-1:0]        pin_lvl,
  output logic [NPINS-1:0]              port_mask
);

  logic                   rst_sync_n;
  logic [NPINS-1:0]       mask_next;
  logic [NPINS-1:0]       mask_q;
  logic [NPINS-1:0]       mask_out_d;
  logic [NPINS*LVL_W-1:0] lvl_d;

  segport_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  segport_sel #(
    .NPINS (NPINS),
    .CNT_W (CNT_W)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (ctl_load),
    .count     (ctl_count),
    .mask_next (mask_next),
    .mask_q    (mask_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    segport_cell #(
      .BITS_PER_PIN (BITS_PER_PIN)
    ) u_cell (
      .port_en   (mask_next[p]),
      .inhibit_n (inhibit_n),
      .psave     (psave),
      .grp       (disp_data[p*BITS_PER_PIN +: BITS_PER_PIN]),
      .seg_in    (seg_lvl[p*LVL_W +: LVL_W]),
      .lvl_out   (lvl_d[p*LVL_W +: LVL_W])
    );
  end

  always_comb begin
    mask_out_d = inhibit_n ? mask_next : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pin_lvl   <= '0;
      port_mask <= '0;
    end else begin
      pin_lvl   <= lvl_d;
      port_mask <= mask_out_d;
    end
  end

endmodule

// File: rtl/segport_mux_chk.sv
module segport_mux_chk
  import segport_pkg::*;
#(
  parameter int NPINS        = 8,
  parameter int BITS_PER_PIN = 3,
  parameter int CNT_W        = 4
) (
  input logic                          clk,
  input logic                          rst_q_n,
  input logic                          ctl_load,
  input logic [CNT_W-1:0]              ctl_count,
  input logic [NPINS*BITS_PER_PIN-1:0] disp_data,
  input logic [NPINS*LVL_W-1:0]        seg_lvl,
  input logic                          inhibit_n,
  input logic                          psave,
  input logic [NPINS*LVL_W-1:0]        pin_lvl,
  input logic [NPINS-1:0]              port_mask
);

  AST_PORT_ORDER: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((port_mask & (port_mask + 1'b1)) == '0)); // R1

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_load && inhibit_n && (int'(ctl_count) <= NPINS)) |=>
      ($countones(port_mask) == int'($past(ctl_count)))); // R1

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_load && inhibit_n && (int'(ctl_count) >= NPINS)) |=> (&port_mask)); // R5

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_load && inhibit_n && $past(inhibit_n)) |=> $stable(port_mask)); // R6

  AST_INH_GROUND: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!inhibit_n) |=> (pin_lvl == '0 && port_mask == '0)); // R8

  for (genvar g = 0; g < NPINS; g++) begin : g_pin_chk
    AST_PORT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_q_n)
      inhibit_n |=> (!port_mask[g] ||
        pin_lvl[g*LVL_W +: LVL_W] == {LVL_W{$past(disp_data[g*BITS_PER_PIN])}})); // R3

    AST_SEG_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
      (inhibit_n && !psave) |=> (port_mask[g] ||
        pin_lvl[g*LVL_W +: LVL_W] == $past(seg_lvl[g*LVL_W +: LVL_W]))); // R4

    AST_PSAVE_GROUND: assert property (@(posedge clk) disable iff (!rst_q_n)
      (inhibit_n && psave) |=> (port_mask[g] || pin_lvl[g*LVL_W +: LVL_W] == '0)); // R7
  end

endmodule

bind segport_mux segport_mux_chk #(
  .NPINS        (NPINS),
  .BITS_PER_PIN (BITS_PER_PIN),
  .CNT_W        (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .ctl_load  (ctl_load),
  .ctl_count (ctl_count),
  .disp_data (disp_data),
  .seg_lvl   (seg_lvl),
  .inhibit_n (inhibit_n),
  .psave     (psave),
  .pin_lvl   (pin_lvl),
  .port_mask (port_mask)
);

// File: tb/segport_mux_tb.sv
`timescale 1ns/1ps
module segport_mux_tb;

  typedef struct packed {
    logic        load;
    logic [3:0]  cnt;
    logic [23:0] data;
    logic [15:0] seg;
    logic        inh;
    logic        ps;
    logic [7:0]  mask;
    logic [15:0] lvl;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  // 24'h249249: only the first display bit of each pin set; 24'hDB6DB6: all others
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd0,  24'h249249, 16'hAAAA, 1'b1, 1'b0, 8'h00, 16'hAAAA, 4'd2},  // R2 count 0
    '{1'b1, 4'd3,  24'h249249, 16'hAAAA, 1'b1, 1'b0, 8'h07, 16'hAABF, 4'd1},  // R1 R3
    '{1'b0, 4'd8,  24'hDB6DB6, 16'h5555, 1'b1, 1'b0, 8'h07, 16'h5540, 4'd6},  // R6 count ignored
    '{1'b1, 4'd8,  24'h249249, 16'h0000, 1'b1, 1'b0, 8'hFF, 16'hFFFF, 4'd2},  // R2 count 8
    '{1'b1, 4'd12, 24'hDB6DB6, 16'hAAAA, 1'b1, 1'b0, 8'hFF, 16'h0000, 4'd5},  // R5 R3 other bits ignored
    '{1'b1, 4'd15, 24'h249249, 16'h0000, 1'b1, 1'b0, 8'hFF, 16'hFFFF, 4'd5},  // R5
    '{1'b1, 4'd5,  24'h249249, 16'h1B1B, 1'b1, 1'b0, 8'h1F, 16'h1BFF, 4'd4},  // R4 R1
    '{1'b0, 4'd0,  24'h249249, 16'h1B1B, 1'b1, 1'b1, 8'h1F, 16'h03FF, 4'd7},  // R7
    '{1'b0, 4'd0,  24'hDB6DB6, 16'h1B1B, 1'b1, 1'b1, 8'h1F, 16'h0000, 4'd7},  // R7 ports follow data
    '{1'b0, 4'd0,  24'h249249, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0000, 4'd8},  // R8
    '{1'b1, 4'd2,  24'h249249, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0000, 4'd8},  // R8 load during inhibit
    '{1'b0, 4'd9,  24'h249249, 16'h0000, 1'b1, 1'b0, 8'h03, 16'h000F, 4'd8},  // R8 selection returns
    '{1'b1, 4'd1,  24'h249249, 16'h5555, 1'b1, 1'b0, 8'h01, 16'h5557, 4'd1},  // R1
    '{1'b1, 4'd7,  24'h249249, 16'h0000, 1'b1, 1'b0, 8'h7F, 16'h3FFF, 4'd1}   // R1
  };

  logic        clk;
  logic        rst_n;
  logic        ctl_load;
  logic [3:0]  ctl_count;
  logic [23:0] disp_data;
  logic [15:0] seg_lvl;
  logic        inhibit_n;
  logic        psave;
  logic [15:0] pin_lvl;
  logic [7:0]  port_mask;

  int n_chk;
  int n_bad;
  bit done;

  segport_mux u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_load  (ctl_load),
    .ctl_count (ctl_count),
    .disp_data (disp_data),
    .seg_lvl   (seg_lvl),
    .inhibit_n (inhibit_n),
    .psave     (psave),
    .pin_lvl   (pin_lvl),
    .port_mask (port_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string rq, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic [3:0] c, input logic [23:0] d,
                       input logic [15:0] s, input logic ih, input logic p);
    @(negedge clk);
    ctl_load  = ld;
    ctl_count = c;
    disp_data = d;
    seg_lvl   = s;
    inhibit_n = ih;
    psave     = p;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    ctl_load = 1'b0;
    ctl_count = 4'd0;
    disp_data = '0;
    seg_lvl = 16'hAAAA;
    inhibit_n = 1'b1;
    psave = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "lvl in reset", pin_lvl, 16'h0000);
    check("R9", "mask in reset", {8'h00, port_mask}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // no load yet: stored count 0, all pins segments
    drive(1'b0, 4'd8, 24'h249249, 16'hAAAA, 1'b1, 1'b0);
    check("R9", "mask after reset", {8'h00, port_mask}, 16'h0000);
    check("R9", "lvl after reset", pin_lvl, 16'hAAAA);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].load, VEC[i].cnt, VEC[i].data, VEC[i].seg, VEC[i].inh, VEC[i].ps);
      check($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d mask", i),
            {8'h00, port_mask}, {8'h00, VEC[i].mask});
      check($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d lvl", i),
            pin_lvl, VEC[i].lvl);
    end

    // R10: output holds until the next rising edge
    @(negedge clk);
    ctl_load = 1'b0;
    seg_lvl  = 16'h8000;
    #1;
    check("R10", "lvl before edge", pin_lvl, 16'h3FFF);
    @(posedge clk);
    #1;
    check("R10", "lvl after edge", pin_lvl, 16'hBFFF);

    // R9: reset clears outputs without a clock edge
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9", "lvl async reset", pin_lvl, 16'h0000);
    check("R9", "mask async reset", {8'h00, port_mask}, 16'h0000);

    finish_run();
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule